// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs a fixed frame of `2^(CNT_W+1)` clocks, which is 8192 at the default `CNT_W = 12`. Each frame has three phases. The first is an auto-zero phase of at least 2048 clocks. The second is a signal-integrate phase of exactly 2048 clocks. The third is a reference-deintegrate window of up to 4096 clocks. One-hot enables drive the analog switches for each phase. During deintegrate, the sign of the reference is chosen from the comparator level sampled at the end of integrate.

A counter runs through the deintegrate window. It stops when the comparator changes level, and that count is the converted magnitude. If the comparator never changes, the window runs out, the result is full scale and the over-range flag is raised. The magnitude, the polarity and the over-range flag are written into output latches once per conversion. STATUS marks the span from the start of integrate to that latch write.

A run/hold input controls whether conversions repeat. With it high, conversions follow one another back to back. With it low, the conversion in progress still finishes. The sequencer then parks in auto-zero `HOLD_LEAD` (7) clocks before the next integrate. When the input goes high again, integrate starts exactly `HOLD_LEAD` clocks later.

Top module: `dslope_seq`

## Requirements
- R1: A synchronous active-high reset places the sequencer at the first auto-zero clock. It clears STATUS, the magnitude, the polarity and the over-range outputs. With run/hold high, integrate begins exactly `2^(CNT_W-1)` clocks after reset is released.
- R2: The integrate enable stays high for exactly `2^(CNT_W-1)` consecutive clocks (2048 by default). With run/hold held high, integrate starts every `2^(CNT_W+1)` clocks (8192 by default).
- R3: The comparator level in the last integrate clock is the polarity. A high level gives polarity 1 and selects the negative-reference enable for deintegrate. A low level gives polarity 0 and selects the positive-reference enable. The other reference enable stays low for the whole conversion.
- R4: Deintegrate clocks are numbered j = 0, 1, ... from the first clock after integrate. A comparator change applied during clock j, for j up to `2^CNT_W - 2`, gives magnitude j+1 with over-range 0. In that case the deintegrate enable stays high for j+2 clocks.
- R5: The window can end with no comparator change, or with a change first applied in its last clock j = `2^CNT_W - 1`. Either way the conversion is over-range: the over-range bit is 1, the magnitude is all ones (4095 by default), and deintegrate lasts `2^CNT_W` clocks.
- R6: The output latches take their new values on the clock after deintegrate ends, and at no other time. STATUS rises with the first integrate clock and falls on that latch clock. STATUS is high for `2^(CNT_W-1)+3+j` clocks for a result from R4, and for `3*2^(CNT_W-1)+1` clocks for an over-range result.
- R7: Exactly one of the four phase enables is high in every clock: auto-zero, integrate, positive-reference deintegrate or negative-reference deintegrate. Auto-zero is high whenever neither integrate nor deintegrate is.
- R8: If run/hold goes low during a conversion, that conversion completes and its result is latched. No further integrate starts while run/hold stays low. Auto-zero stays enabled and STATUS stays low.
- R9: Run/hold may return high while the sequencer is parked. If it is high at the clock edge that ends parked cycle c, integrate starts in cycle c + `HOLD_LEAD` and not before.
- R10: Comparator changes during auto-zero or integrate (other than in the last integrate clock) have no effect on the magnitude, polarity or over-range result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| run_hold_i | input | 1 | High: convert continuously; low: finish and park before integrate |
| comp_i | input | 1 | Comparator output (sign of the integrator) |
| az_en_o | output | 1 | Auto-zero switch enable |
| int_en_o | output | 1 | Signal-integrate switch enable |
| deint_pos_en_o | output | 1 | Deintegrate with positive reference (input was negative) |
| deint_neg_en_o | output | 1 | Deintegrate with negative reference (input was positive) |
| status_o | output | 1 | High from integrate start until the result latch update |
| mag_o | output | CNT_W | Latched magnitude |
| pol_o | output | 1 | Latched polarity, 1 = positive |
| ovr_o | output | 1 | Latched over-range flag |

## Verification
Several rules are checked by the assertions on every clock: one-hot phase enables, the exact integrate length, the bound on deintegrate length, an over-range result always reading full scale, latch values held except on the STATUS falling edge, and STATUS rising only together with integrate. Other behaviour can only be shown by scenarios, because it depends on where the comparator edge falls in the frame. The bench sweeps that edge across every deintegrate clock for both polarities, including the no-edge case. It checks the exact magnitude, the deintegrate and STATUS durations and the frame period. Separate scenarios cover run/hold parking and resuming, comparator glitches during integrate, and a reset applied after a result has been latched.

// File: rtl/dslope_pkg.sv
`timescale 1ns/1ps
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;
endpackage

// File: rtl/dslope_frame_timer.sv
`timescale 1ns/1ps
// Free-running frame position counter with the run/hold parking point.
module dslope_frame_timer #(
  parameter int CNT_W     = 12,
  parameter int HOLD_LEAD = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_hold_i,
  output logic             in_int_o,
  output logic             int_last_o,
  output logic             win_last_o,
  output logic             frame_wrap_o,
  output logic [CNT_W-1:0] deint_idx_o
);
  localparam int FW        = CNT_W + 1;
  localparam int DEINT_MAX = 1 << CNT_W;
  localparam int INT_LEN   = DEINT_MAX / 2;
  localparam int AZ_START  = INT_LEN + DEINT_MAX;
  localparam int FRAME     = 1 << FW;
  localparam int HOLD_PT   = FRAME - HOLD_LEAD;

  logic [FW-1:0] pos_q;
  logic          advance;

  // Parking only happens at the hold point; everywhere else the frame runs.
  assign advance = run_hold_i || (pos_q != FW'(HOLD_PT));

  always_ff @(posedge clk) begin
    if (rst)          pos_q <= FW'(AZ_START);
    else if (advance) pos_q <= pos_q + 1'b1;
  end

  assign in_int_o     = pos_q < FW'(INT_LEN);
  assign int_last_o   = pos_q == FW'(INT_LEN - 1);
  assign win_last_o   = pos_q == FW'(AZ_START - 1);
  assign frame_wrap_o = advance && (pos_q == FW'(FRAME - 1));
  assign deint_idx_o  = CNT_W'(pos_q - FW'(INT_LEN));
endmodule

// File: rtl/dslope_zero_detect.sv
`timescale 1ns/1ps
// Comparator synchronizer and level-change detector.
module dslope_zero_detect #(
  parameter int SYNC_LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic comp_i,
  output logic level_o,
  output logic edge_o
);
  logic [SYNC_LEN-1:0] chain_q;
  logic                prev_q;

  generate
    if (SYNC_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= comp_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_LEN-2:0], comp_i};
      end
    end
  endgenerate

  assign level_o = chain_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_o;
  end

  assign edge_o = level_o ^ prev_q;
endmodule

// File: rtl/dslope_result_capture.sv
`timescale 1ns/1ps
// Deintegrate tracking, count capture, polarity and over-range, output latches.
module dslope_result_capture #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_last_i,
  input  logic             win_last_i,
  input  logic             edge_i,
  input  logic             level_i,
  input  logic [CNT_W-1:0] deint_idx_i,
  output logic             deint_act_o,
  output logic             sign_o,
  output logic             load_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             pol_o,
  output logic             ovr_o
);
  logic             act_q;
  logic             sign_q;
  logic             load_q;
  logic             ovr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      sign_q <= 1'b0;
      load_q <= 1'b0;
      ovr_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (int_last_i) begin
        sign_q <= level_i;
        act_q  <= 1'b1;
      end else if (act_q && edge_i) begin
        cnt_q  <= deint_idx_i;
        ovr_q  <= 1'b0;
        act_q  <= 1'b0;
        load_q <= 1'b1;
      end else if (act_q && win_last_i) begin
        cnt_q  <= '1;
        ovr_q  <= 1'b1;
        act_q  <= 1'b0;
        load_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_o <= '0;
      pol_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (load_q) begin
      mag_o <= cnt_q;
      pol_o <= sign_q;
      ovr_o <= ovr_q;
    end
  end

  assign deint_act_o = act_q;
  assign sign_o      = sign_q;
  assign load_o      = load_q;
endmodule

// File: rtl/dslope_seq.sv
`timescale 1ns/1ps
// Dual-slope conversion phase sequencer, top level.
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int HOLD_LEAD = 7,
  parameter int SYNC_LEN  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_hold_i,
  input  logic             comp_i,
  output logic             az_en_o,
  output logic             int_en_o,
  output logic             deint_pos_en_o,
  output logic             deint_neg_en_o,
  output logic             status_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             pol_o,
  output logic             ovr_o
);
  logic             in_int;
  logic             int_last;
  logic             win_last;
  logic             frame_wrap;
  logic [CNT_W-1:0] deint_idx;
  logic             level;
  logic             cmp_edge;
  logic             deint_act;
  logic             sign;
  logic             load;
  logic             status_q;
  phase_e           phase;

  dslope_frame_timer #(.CNT_W(CNT_W), .HOLD_LEAD(HOLD_LEAD)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run_hold_i   (run_hold_i),
    .in_int_o     (in_int),
    .int_last_o   (int_last),
    .win_last_o   (win_last),
    .frame_wrap_o (frame_wrap),
    .deint_idx_o  (deint_idx)
  );

  dslope_zero_detect #(.SYNC_LEN(SYNC_LEN)) u_zdet (
    .clk     (clk),
    .rst     (rst),
    .comp_i  (comp_i),
    .level_o (level),
    .edge_o  (cmp_edge)
  );

  dslope_result_capture #(.CNT_W(CNT_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .int_last_i  (int_last),
    .win_last_i  (win_last),
    .edge_i      (cmp_edge),
    .level_i     (level),
    .deint_idx_i (deint_idx),
    .deint_act_o (deint_act),
    .sign_o      (sign),
    .load_o      (load),
    .mag_o       (mag_o),
    .pol_o       (pol_o),
    .ovr_o       (ovr_o)
  );

  always_comb begin
    if (in_int)         phase = PH_INT;
    else if (deint_act) phase = PH_DEINT;
    else                phase = PH_AZ;
  end

  assign az_en_o        = (phase == PH_AZ);
  assign int_en_o       = (phase == PH_INT);
  assign deint_neg_en_o = (phase == PH_DEINT) &&  sign;
  assign deint_pos_en_o = (phase == PH_DEINT) && !sign;

  always_ff @(posedge clk) begin
    if (rst)             status_q <= 1'b0;
    else if (frame_wrap) status_q <= 1'b1;
    else if (load)       status_q <= 1'b0;
  end

  assign status_o = status_q;
endmodule

// File: rtl/dslope_seq_chk.sv
`timescale 1ns/1ps
// Property checker attached to dslope_seq.
module dslope_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             az_en_o,
  input logic             int_en_o,
  input logic             deint_pos_en_o,
  input logic             deint_neg_en_o,
  input logic             status_o,
  input logic [CNT_W-1:0] mag_o,
  input logic             pol_o,
  input logic             ovr_o
);
  localparam int DEINT_MAX = 1 << CNT_W;
  localparam int INT_LEN   = DEINT_MAX / 2;
  localparam int RW        = CNT_W + 2;

  logic [RW-1:0] int_run;
  logic [RW-1:0] dei_run;
  logic          dei_any;

  assign dei_any = deint_pos_en_o || deint_neg_en_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_run <= '0;
      dei_run <= '0;
    end else begin
      int_run <= int_en_o ? int_run + 1'b1 : '0;
      dei_run <= dei_any  ? dei_run + 1'b1 : '0;
    end
  end

  a_r7_onehot_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot({az_en_o, int_en_o, deint_pos_en_o, deint_neg_en_o}));

  a_r2_int_length: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(int_en_o)) |-> (int_run == RW'(INT_LEN)));

  a_r5_deint_bound: assert property (@(posedge clk) disable iff (rst)
    dei_any |-> (dei_run < RW'(DEINT_MAX)));

  a_r5_ovr_full_scale: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> (&mag_o));

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$fell(status_o)) |-> $stable({mag_o, pol_o, ovr_o}));

  a_r6_status_start: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $rose(status_o)) |-> int_en_o);

  a_r3_ref_sign_steady: assert property (@(posedge clk) disable iff (rst)
    deint_pos_en_o |=> !deint_neg_en_o);
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .az_en_o        (az_en_o),
  .int_en_o       (int_en_o),
  .deint_pos_en_o (deint_pos_en_o),
  .deint_neg_en_o (deint_neg_en_o),
  .status_o       (status_o),
  .mag_o          (mag_o),
  .pol_o          (pol_o),
  .ovr_o          (ovr_o)
);

// File: tb/dslope_seq_test.sv
`timescale 1ns/1ps
module dslope_seq_test;
  localparam int CW  = 5;
  localparam int HL  = 7;
  localparam int DM  = 1 << CW;
  localparam int IL  = DM / 2;
  localparam int AZS = IL + DM;
  localparam int FR  = 2 * DM;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_hold = 1'b1;
  logic          comp = 1'b0;
  logic          az_en, int_en, dpos, dneg, status, pol, ovr;
  logic [CW-1:0] mag;

  int cyc_cnt    = 0;
  int checks     = 0;
  int fails      = 0;
  int prev_start = -1;

  dslope_seq #(.CNT_W(CW), .HOLD_LEAD(HL)) uut (
    .clk            (clk),
    .rst            (rst),
    .run_hold_i     (run_hold),
    .comp_i         (comp),
    .az_en_o        (az_en),
    .int_en_o       (int_en),
    .deint_pos_en_o (dpos),
    .deint_neg_en_o (dneg),
    .status_o       (status),
    .mag_o          (mag),
    .pol_o          (pol),
    .ovr_o          (ovr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One conversion; caller is at a negedge. j < 0 means no comparator change.
  task automatic convert(input logic p, input int j, input bit glitch, input bit drop);
    int c = 0, ni = 0, nd = 0, nx = 0, start;
    int exp_m, exp_st, exp_d;
    bit ov;
    comp = p;
    while (!int_en) @(negedge clk);
    start = cyc_cnt;
    if (prev_start >= 0) check("R2", "frame period", start - prev_start, FR);
    prev_start = start;
    while (status && c < 4 * FR) begin
      if (int_en) ni++;
      if (p ? dneg : dpos) nd++;
      if (p ? dpos : dneg) nx++;
      if (glitch && c == 3) comp = ~p;   // R10 glitch inside integrate
      if (glitch && c == 6) comp = p;
      if (drop && c == IL + 1) run_hold = 1'b0;
      if (j >= 0 && c == IL + j) comp = ~p;
      @(negedge clk);
      c++;
    end
    ov     = !(j >= 0 && j <= DM - 2);
    exp_m  = ov ? DM - 1 : j + 1;
    exp_st = ov ? AZS + 1 : IL + 3 + j;
    exp_d  = ov ? DM : j + 2;
    check("R2", "integrate length", ni, IL);
    check("R3", "wrong reference enable cycles", nx, 0);
    check("R3", "polarity", int'(pol), int'(p));
    if (ov) begin
      check("R5", "over-range magnitude", int'(mag), exp_m);
      check("R5", "over-range flag", int'(ovr), 1);
      check("R5", "deintegrate length", nd, exp_d);
    end else begin
      check(glitch ? "R10" : "R4", "magnitude", int'(mag), exp_m);
      check("R4", "over-range flag", int'(ovr), 0);
      check("R4", "deintegrate length", nd, exp_d);
    end
    check("R6", "status length", c, exp_st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c;
    int bad_int;
    int bad_az;
    int bad_st;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "az_en after reset", int'(az_en), 1);
    check("R1", "int_en after reset", int'(int_en), 0);
    check("R1", "status after reset", int'(status), 0);
    check("R1", "mag after reset", int'(mag), 0);
    check("R1", "pol after reset", int'(pol), 0);
    check("R1", "ovr after reset", int'(ovr), 0);
    c = 0;
    while (!int_en && c < FR) begin
      @(negedge clk);
      c++;
    end
    check("R1", "auto-zero length after reset", c, IL);

    // Sweep of the crossing position over the whole window, both polarities
    for (int p = 0; p < 2; p++)
      for (int j = -1; j < DM; j++)
        convert(p[0], j, 1'b0, 1'b0);

    // R10 comparator activity during integrate is ignored
    convert(1'b1, 5, 1'b1, 1'b0);
    convert(1'b0, 12, 1'b1, 1'b0);

    // R8 run/hold drops during deintegrate: conversion completes, then parks
    convert(1'b1, 10, 1'b0, 1'b1);
    bad_int = 0;
    bad_az  = 0;
    bad_st  = 0;
    for (int k = 0; k < 3 * FR; k++) begin
      if (int_en)  bad_int++;
      if (!az_en)  bad_az++;
      if (status)  bad_st++;
      @(negedge clk);
    end
    check("R8", "integrate cycles while held", bad_int, 0);
    check("R8", "non-auto-zero cycles while held", bad_az, 0);
    check("R8", "status cycles while held", bad_st, 0);
    check("R8", "held magnitude", int'(mag), 11);

    // R9 resume: integrate exactly HOLD_LEAD cycles after run/hold returns
    run_hold = 1'b1;
    for (int k = 1; k <= HL; k++) begin
      @(negedge clk);
      if (k == HL - 1) check("R9", "int_en one cycle before resume point", int'(int_en), 0);
      if (k == HL)     check("R9", "int_en at resume point", int'(int_en), 1);
    end
    prev_start = -1;
    convert(1'b1, 3, 1'b0, 1'b0);
    convert(1'b0, 20, 1'b0, 1'b0);
    convert(1'b1, 7, 1'b0, 1'b0);

    // R1 reset clears latched results
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "mag cleared by reset", int'(mag), 0);
    check("R1", "pol cleared by reset", int'(pol), 0);
    check("R1", "status cleared by reset", int'(status), 0);
    check("R1", "az_en during reset", int'(az_en), 1);
    rst = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule